// File: doc/BRIEF.md
# Storage Controller Register and Doorbell Decoder

This block is the memory-mapped register front end of a queue-based storage controller. It accepts single-cycle register writes. It holds the interrupt mask, the controller configuration word, the admin queue attributes and the two 64-bit admin queue base addresses. It also keeps the controller status bits: ready, failed and shutdown complete. A rising enable bit starts a validation of the programmed configuration. When the check passes, the admin queue pair (queue 0) is installed in a per-queue table of valid flags and entry counts.

Writes at or above byte address 0x1000 are doorbells. Each queue owns an 8-byte slot. The submission tail doorbell is the first word of the slot and the completion head doorbell is the second. An accepted doorbell appears for one cycle on a registered update port. A submission tail doorbell also arms a per-queue countdown that raises a one-cycle fetch request later. The table entries for I/O queues are written through a side port by whatever executes the create and delete commands. Disabling the controller or raising the shutdown notification clears the whole table.

Top module: `ctl_regfront`

## Requirements
- R1: After reset the status word (0x1C) and the mask read 0. The version word (0x08) reads 0x00010001. The capability low word (0x00) reads 0x0F0307FF and the capability high word (0x04) reads 0x00400020 with default parameters.
- R2: Writing 0x0C ORs the data into the interrupt mask. Writing 0x10 clears the mask bits that are set in the data. Reads of either offset return the mask.
- R3: The admin attributes at 0x24 read back as written. So do the admin submission base halves at 0x28 (low) and 0x2C (high) and the admin completion base halves at 0x30 (low) and 0x34 (high).
- R4: The configuration word is at 0x14, with the fields enable [0], page exponent [10:7], submission entry exponent [19:16] and completion entry exponent [23:20]. When the enable bit goes from 0 to 1, the whole word is stored and validated. The status word then becomes 0x1 (ready) on success or 0x2 (failed) on failure. A write that changes neither the enable bit nor the shutdown field leaves the stored word unchanged.
- R5: Validation fails in any of these cases: a page exponent outside 0..4; a submission exponent other than 6; a completion exponent other than 4; either admin base equal to zero; either admin base not aligned to 4096<<exponent bytes; a zero admin submission size field (0x24 bits [11:0]); a zero admin completion size field (0x24 bits [27:16]).
- R6: When the enable bit goes from 1 to 0, the stored word becomes 0 and ready clears while failed is kept. All queues become invalid and q_flush pulses for one cycle.
- R7: Shutdown notification is the field [15:14]. Going from zero to non-zero stores the word, sets status bit 3, invalidates all queues and pulses q_flush. Going back to zero stores the word and clears bit 3.
- R8: A write at 0x1000+8q updates the submission tail of queue q. A write at 0x1000+8q+4 updates its completion head. One cycle after an accepted write, db_valid is high with db_cq (1 for a head), db_qid and db_value (the low 16 bits of the data).
- R9: A doorbell is ignored in each of these cases: the address is not 4-byte aligned; q is 64 or above; the queue of that kind is not valid; the 16-bit value is greater than or equal to the queue's entry count.
- R10: An accepted submission tail for queue q raises fetch_req[q] for one cycle, starting 3 cycles after the cycle that db_valid rises. A repeated tail write while the countdown runs restarts it, so only one request follows.
- R11: A successful enable makes queue 0 valid with submission entry count equal to the size field [11:0] + 1 and completion entry count equal to the size field [27:16] + 1.
- R12: While ready, qc_en with qc_create=1 makes queue qc_id of the kind qc_cq valid with qc_size entries, and qc_create=0 makes it invalid. Requests for queue 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register or doorbell write strobe |
| wr_addr | input | 13 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 13 | Byte address of the read |
| rd_data | output | 32 | Combinational read data |
| qc_en | input | 1 | Queue table update strobe |
| qc_create | input | 1 | 1 creates the queue, 0 deletes it |
| qc_cq | input | 1 | 1 selects the completion side, 0 the submission side |
| qc_id | input | 6 | Queue index to update |
| qc_size | input | 16 | Entry count for a create |
| db_valid | output | 1 | Accepted doorbell, one cycle |
| db_cq | output | 1 | Doorbell was a completion head |
| db_qid | output | 6 | Queue of the accepted doorbell |
| db_value | output | 16 | New tail or head value |
| fetch_req | output | 64 | Per-queue delayed fetch request pulses |
| q_flush | output | 1 | One-cycle pulse when all queues are torn down |

## Verification
The bench runs every validation failure cause against a good baseline. A design that tested only the low base half, or ignored the page exponent in the alignment mask, would report ready where failed is expected. It installs all 64 queue pairs with distinct sizes and writes the largest legal value and the first illegal value to both doorbells of each. An off-by-one in the size compare, or swapped head and tail slots, shows up on the update port. The fetch countdown is checked cycle by cycle, including a restart that must suppress the original pulse. The enable, disable and shutdown edges are checked for correct status bits and for teardown: a design that left queues valid would still accept doorbells afterwards.

// File: rtl/ctl_regfront.sv
module ctl_regfront #(
  parameter int          NQ        = 64,
  parameter int          QIDW      = 6,
  parameter int          AW        = 13,
  parameter int          FETCH_DLY = 4,
  parameter int          MPS_MIN   = 0,
  parameter int          MPS_MAX   = 4,
  parameter int          SQES_MIN  = 6,
  parameter int          SQES_MAX  = 6,
  parameter int          CQES_MIN  = 4,
  parameter int          CQES_MAX  = 4,
  parameter logic [15:0] MQES      = 16'h07ff
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [31:0]     wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [31:0]     rd_data,
  input  logic            qc_en,
  input  logic            qc_create,
  input  logic            qc_cq,
  input  logic [QIDW-1:0] qc_id,
  input  logic [15:0]     qc_size,
  output logic            db_valid,
  output logic            db_cq,
  output logic [QIDW-1:0] db_qid,
  output logic [15:0]     db_value,
  output logic [NQ-1:0]   fetch_req,
  output logic            q_flush
);

  localparam int CW = $clog2(FETCH_DLY + 1);
  localparam logic [AW-1:0] A_CAPL = AW'(8'h00);
  localparam logic [AW-1:0] A_CAPH = AW'(8'h04);
  localparam logic [AW-1:0] A_VS   = AW'(8'h08);
  localparam logic [AW-1:0] A_IMS  = AW'(8'h0C);
  localparam logic [AW-1:0] A_IMC  = AW'(8'h10);
  localparam logic [AW-1:0] A_CC   = AW'(8'h14);
  localparam logic [AW-1:0] A_CSTS = AW'(8'h1C);
  localparam logic [AW-1:0] A_AQA  = AW'(8'h24);
  localparam logic [AW-1:0] A_ASQL = AW'(8'h28);
  localparam logic [AW-1:0] A_ASQH = AW'(8'h2C);
  localparam logic [AW-1:0] A_ACQL = AW'(8'h30);
  localparam logic [AW-1:0] A_ACQH = AW'(8'h34);
  localparam logic [AW-1:0] A_DB   = AW'(16'h1000);
  localparam logic [AW-4:0] NQ_LIM = (AW-3)'(NQ);
  localparam logic [CW-1:0] CNT_LOAD = CW'(FETCH_DLY);

  function automatic logic rng_ok(input logic [3:0] v, input int lo, input int hi);
    logic [3:0] d;
    d = v - 4'(lo);
    return d <= 4'(hi - lo);
  endfunction

  logic [31:0] imask, cc, aqa;
  logic [63:0] asq, acq;
  logic        rdy, cfs, shst;
  logic [NQ-1:0] sq_vld, cq_vld;
  logic [15:0]   sq_sz [NQ];
  logic [15:0]   cq_sz [NQ];
  logic [CW-1:0] cnt   [NQ];

  logic bar_wr, cc_wr, en_rise, en_fall, shn_rise, shn_fall, teardown, cfg_bad, admin_up;
  logic [31:0] cc_mid, cc_nxt;
  logic [63:0] pg_mask;
  logic [AW-1:0] db_off;
  logic [QIDW-1:0] db_q;
  logic db_in, sq_hit, cq_hit;

  assign bar_wr = wr_en && (wr_addr < A_DB);
  assign cc_wr  = bar_wr && (wr_addr == A_CC);

  assign en_rise  = cc_wr && wr_data[0] && !cc[0];
  assign en_fall  = cc_wr && !wr_data[0] && cc[0];
  assign cc_mid   = en_rise ? wr_data : (en_fall ? 32'd0 : cc);
  assign shn_rise = cc_wr && (wr_data[15:14] != 2'b00) && (cc_mid[15:14] == 2'b00);
  assign shn_fall = cc_wr && (wr_data[15:14] == 2'b00) && (cc_mid[15:14] != 2'b00);
  assign cc_nxt   = (shn_rise || shn_fall) ? wr_data : cc_mid;
  assign teardown = en_fall || shn_rise;

  assign pg_mask = (64'h1000 << wr_data[10:7]) - 64'd1;
  assign cfg_bad = (asq == 64'd0) || (acq == 64'd0) ||
                   ((asq & pg_mask) != 64'd0) || ((acq & pg_mask) != 64'd0) ||
                   !rng_ok(wr_data[10:7], MPS_MIN, MPS_MAX) ||
                   !rng_ok(wr_data[19:16], SQES_MIN, SQES_MAX) ||
                   !rng_ok(wr_data[23:20], CQES_MIN, CQES_MAX) ||
                   (aqa[11:0] == 12'd0) || (aqa[27:16] == 12'd0);
  assign admin_up = en_rise && !cfg_bad;

  assign db_off = wr_addr - A_DB;
  assign db_q   = db_off[QIDW+2:3];
  assign db_in  = wr_en && !(wr_addr < A_DB) && (wr_addr[1:0] == 2'b00) &&
                  (db_off[AW-1:3] < NQ_LIM);
  assign sq_hit = db_in && !db_off[2] && sq_vld[db_q] && (wr_data[15:0] < sq_sz[db_q]);
  assign cq_hit = db_in &&  db_off[2] && cq_vld[db_q] && (wr_data[15:0] < cq_sz[db_q]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imask <= '0; cc <= '0; aqa <= '0; asq <= '0; acq <= '0;
      rdy <= 1'b0; cfs <= 1'b0; shst <= 1'b0;
      q_flush <= 1'b0; db_valid <= 1'b0; db_cq <= 1'b0; db_qid <= '0; db_value <= '0;
      sq_vld <= '0; cq_vld <= '0;
      for (int i = 0; i < NQ; i++) begin
        sq_sz[i] <= '0; cq_sz[i] <= '0; cnt[i] <= '0;
      end
    end else begin
      q_flush  <= teardown;
      db_valid <= sq_hit || cq_hit;
      if (sq_hit || cq_hit) begin
        db_cq    <= db_off[2];
        db_qid   <= db_q;
        db_value <= wr_data[15:0];
      end
      if (bar_wr) begin
        case (wr_addr)
          A_IMS:  imask <= imask | wr_data;
          A_IMC:  imask <= imask & ~wr_data;
          A_AQA:  aqa <= wr_data;
          A_ASQL: asq[31:0]  <= wr_data;
          A_ASQH: asq[63:32] <= wr_data;
          A_ACQL: acq[31:0]  <= wr_data;
          A_ACQH: acq[63:32] <= wr_data;
          default: ;
        endcase
      end
      cc <= cc_nxt;
      if (en_rise) begin
        rdy  <= !cfg_bad;
        cfs  <= cfg_bad;
        shst <= 1'b0;
      end else if (en_fall) begin
        rdy <= 1'b0;
      end
      if (shn_rise)      shst <= 1'b1;
      else if (shn_fall) shst <= 1'b0;

      for (int i = 0; i < NQ; i++) begin
        if (teardown) begin
          sq_vld[i] <= 1'b0;
          cq_vld[i] <= 1'b0;
          cnt[i]    <= '0;
        end else begin
          if (i == 0 && admin_up) begin
            sq_vld[i] <= 1'b1;
            cq_vld[i] <= 1'b1;
            sq_sz[i]  <= {4'h0, aqa[11:0]} + 16'd1;
            cq_sz[i]  <= {4'h0, aqa[27:16]} + 16'd1;
          end else if (i != 0 && qc_en && rdy && qc_id == QIDW'(i)) begin
            if (qc_cq) begin
              cq_vld[i] <= qc_create;
              if (qc_create) cq_sz[i] <= qc_size;
            end else begin
              sq_vld[i] <= qc_create;
              if (qc_create) sq_sz[i] <= qc_size;
            end
          end
          if (sq_hit && db_q == QIDW'(i))
            cnt[i] <= CNT_LOAD;
          else if (i != 0 && qc_en && rdy && !qc_cq && !qc_create && qc_id == QIDW'(i))
            cnt[i] <= '0;
          else if (cnt[i] != '0)
            cnt[i] <= cnt[i] - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_fetch
    assign fetch_req[g] = (cnt[g] == CW'(1));
  end

  always_comb begin
    case (rd_addr)
      A_CAPL:        rd_data = {8'h0F, 5'd0, 2'b01, 1'b1, MQES};
      A_CAPH:        rd_data = {8'h00, 4'(MPS_MAX), 4'(MPS_MIN), 10'd0, 1'b1, 5'd0};
      A_VS:          rd_data = 32'h0001_0001;
      A_IMS, A_IMC:  rd_data = imask;
      A_CC:          rd_data = cc;
      A_CSTS:        rd_data = {28'd0, shst, 1'b0, cfs, rdy};
      A_AQA:         rd_data = aqa;
      A_ASQL:        rd_data = asq[31:0];
      A_ASQH:        rd_data = asq[63:32];
      A_ACQL:        rd_data = acq[31:0];
      A_ACQH:        rd_data = acq[63:32];
      default:       rd_data = 32'd0;
    endcase
  end

  AST_IMASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_IMS) |=> ((imask & $past(wr_data)) == $past(wr_data))); // R2
  AST_RDY_NOT_FAILED: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdy && cfs)); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush |-> (sq_vld == '0 && cq_vld == '0)); // R6
  AST_DB_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |-> $past(wr_en)); // R8
  AST_FETCH_NEEDS_SQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req & ~sq_vld) == '0); // R10

endmodule

// File: tb/tb_ctl_regfront.sv
`timescale 1ns/1ps
module tb_ctl_regfront;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [12:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  wire  [31:0] rd_data;
  logic qc_en = 1'b0, qc_create = 1'b0, qc_cq = 1'b0;
  logic [5:0]  qc_id = '0;
  logic [15:0] qc_size = '0;
  wire db_valid, db_cq, q_flush;
  wire [5:0]  db_qid;
  wire [15:0] db_value;
  wire [63:0] fetch_req;
  int checks = 0, errors = 0;

  localparam logic [31:0] CC_GOOD = 32'h0046_0001;

  ctl_regfront dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .qc_en(qc_en), .qc_create(qc_create),
    .qc_cq(qc_cq), .qc_id(qc_id), .qc_size(qc_size), .db_valid(db_valid),
    .db_cq(db_cq), .db_qid(db_qid), .db_value(db_value), .fetch_req(fetch_req),
    .q_flush(q_flush)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [12:0] a, input logic [31:0] exp);
    rd_addr = a; #1; chk(tag, rd_data, exp);
  endtask

  task automatic qcfg(input int id, input logic cq, input logic create, input int size);
    @(negedge clk); qc_en = 1'b1; qc_id = 6'(id); qc_cq = cq; qc_create = create; qc_size = 16'(size);
    @(negedge clk); qc_en = 1'b0;
  endtask

  task automatic db(input string tag, input logic [12:0] a, input int val,
                    input logic ok, input logic cq, input int q);
    wr(a, 32'(val) | 32'hABCD_0000);
    if (ok) chk(tag, {db_valid, db_cq, db_qid, db_value}, {1'b1, cq, 6'(q), 16'(val)});
    else    chk(tag, {63'd0, db_valid}, 64'd0);
  endtask

  task automatic set_regs(input logic [63:0] sq, input logic [63:0] cq, input logic [31:0] attr);
    wr(13'h28, sq[31:0]); wr(13'h2C, sq[63:32]);
    wr(13'h30, cq[31:0]); wr(13'h34, cq[63:32]);
    wr(13'h24, attr);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rdchk("R1 status", 13'h1C, 32'h0);
    rdchk("R1 mask", 13'h0C, 32'h0);
    rdchk("R1 version", 13'h08, 32'h0001_0001);
    rdchk("R1 cap low", 13'h00, 32'h0F03_07FF);
    rdchk("R1 cap high", 13'h04, 32'h0040_0020);

    m = 32'h0;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] d;
      d = (32'h1 << i) | (i[0] ? 32'h0 : 32'h0000_0300);
      wr(13'h0C, d); m = m | d;
      rdchk("R2 mask set", 13'h0C, m);
    end
    for (int i = 0; i < 32; i += 3) begin
      logic [31:0] d;
      d = 32'h5 << i;
      wr(13'h10, d); m = m & ~d;
      rdchk("R2 mask clear", 13'h10, m);
    end

    set_regs(64'h1234_5678_0000_2000, 64'h0000_00AB_0000_3000, 32'h0FFF_0ABC);
    rdchk("R3 asq low", 13'h28, 32'h0000_2000);
    rdchk("R3 asq high", 13'h2C, 32'h1234_5678);
    rdchk("R3 acq low", 13'h30, 32'h0000_3000);
    rdchk("R3 acq high", 13'h34, 32'h0000_00AB);
    rdchk("R3 attributes", 13'h24, 32'h0FFF_0ABC);

    for (int k = 0; k < 12; k++) begin
      logic [63:0] s, c;
      logic [31:0] at, ccv;
      logic good;
      s = 64'h2000; c = 64'h3000; at = 32'h0005_0003; ccv = CC_GOOD; good = 1'b0;
      case (k)
        0: s = 64'h0;
        1: c = 64'h0;
        2: s = 64'h1800;
        3: c = 64'h3010;
        4: ccv = 32'h0046_0001 | (32'd5 << 7);
        5: ccv = 32'h0047_0001;
        6: ccv = 32'h0036_0001;
        7: at = 32'h0005_0000;
        8: at = 32'h0000_0003;
        9: begin s = 64'h3000; ccv = CC_GOOD | (32'd1 << 7); end
        10: begin s = 64'h4000; c = 64'h6000; ccv = CC_GOOD | (32'd1 << 7); good = 1'b1; end
        default: begin s = 64'h1_0000_0000; good = 1'b1; end
      endcase
      wr(13'h14, 32'h0);
      set_regs(s, c, at);
      wr(13'h14, ccv);
      rdchk($sformatf("R5 validation case %0d", k), 13'h1C, good ? 32'h1 : 32'h2);
      rdchk("R4 stored config", 13'h14, ccv);
      if (k == 8) begin
        wr(13'h14, 32'h0);
        rdchk("R6 failed kept after disable", 13'h1C, 32'h2);
      end
    end

    wr(13'h14, 32'h0);
    chk("R6 flush pulse", {63'd0, q_flush}, 64'd1);
    rdchk("R6 config cleared", 13'h14, 32'h0);
    set_regs(64'h2000, 64'h3000, 32'h0005_0003);
    wr(13'h14, CC_GOOD);
    rdchk("R4 ready", 13'h1C, 32'h1);
    wr(13'h14, CC_GOOD | (32'd2 << 7));
    rdchk("R4 no edge keeps config", 13'h14, CC_GOOD);

    db("R11 admin sq max", 13'h1000, 3, 1'b1, 1'b0, 0);
    db("R11 admin sq size", 13'h1000, 4, 1'b0, 1'b0, 0);
    db("R11 admin cq max", 13'h1004, 5, 1'b1, 1'b1, 0);
    db("R11 admin cq size", 13'h1004, 6, 1'b0, 1'b1, 0);

    repeat (8) @(negedge clk);
    wr(13'h1000, 32'd1);
    chk("R10 fetch idle at write", fetch_req, 64'd0);
    repeat (2) @(negedge clk);
    chk("R10 fetch before delay", fetch_req, 64'd0);
    @(negedge clk);
    chk("R10 fetch pulse", fetch_req, 64'd1);
    @(negedge clk);
    chk("R10 fetch one cycle", fetch_req, 64'd0);
    wr(13'h1000, 32'd2);
    wr(13'h1000, 32'd3);
    repeat (2) @(negedge clk);
    chk("R10 restart suppresses old pulse", fetch_req, 64'd0);
    @(negedge clk);
    chk("R10 restarted pulse", fetch_req, 64'd1);
    @(negedge clk);
    chk("R10 single restarted pulse", fetch_req, 64'd0);
    wr(13'h1004, 32'd1);
    repeat (4) begin
      @(negedge clk);
      chk("R10 head doorbell no fetch", fetch_req, 64'd0);
    end

    qcfg(0, 1'b0, 1'b1, 100);
    db("R12 queue 0 port ignored", 13'h1000, 50, 1'b0, 1'b0, 0);
    for (int q = 1; q < 64; q++) begin
      qcfg(q, 1'b0, 1'b1, q + 1);
      qcfg(q, 1'b1, 1'b1, q + 2);
    end
    for (int q = 1; q < 64; q++) begin
      db("R8 sq tail max", 13'(32'h1000 + 8 * q), q, 1'b1, 1'b0, q);
      db("R9 sq tail at size", 13'(32'h1000 + 8 * q), q + 1, 1'b0, 1'b0, q);
      db("R8 cq head max", 13'(32'h1004 + 8 * q), q + 1, 1'b1, 1'b1, q);
      db("R9 cq head at size", 13'(32'h1004 + 8 * q), q + 2, 1'b0, 1'b1, q);
    end
    qcfg(5, 1'b0, 1'b0, 0);
    db("R12 deleted sq ignored", 13'h1028, 1, 1'b0, 1'b0, 5);
    db("R12 cq of deleted sq kept", 13'h102C, 1, 1'b1, 1'b1, 5);
    db("R9 misaligned ignored", 13'h1002, 1, 1'b0, 1'b0, 0);
    db("R9 queue 64 ignored", 13'h1200, 0, 1'b0, 1'b0, 0);

    wr(13'h14, CC_GOOD | 32'h0000_4000);
    chk("R7 flush pulse", {63'd0, q_flush}, 64'd1);
    rdchk("R7 shutdown complete", 13'h1C, 32'h9);
    db("R7 queues torn down", 13'h1000, 1, 1'b0, 1'b0, 0);
    wr(13'h14, CC_GOOD);
    rdchk("R7 shutdown cleared", 13'h1C, 32'h1);
    rdchk("R7 config stored", 13'h14, CC_GOOD);

    wr(13'h14, 32'h0);
    chk("R6 flush on disable", {63'd0, q_flush}, 64'd1);
    rdchk("R6 ready cleared", 13'h1C, 32'h0);
    db("R6 doorbell after disable", 13'h1004, 1, 1'b0, 1'b1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule